// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block collects every reason a chip may need to restart and turns them into a single active-low system reset. The reasons are:

- power-on
- a qualified external reset pin
- watchdog expiry
- PLL unlock
- PLL clock loss
- a software request
- a low-supply warning

Once the last active source goes away, the reset output stays low for a fixed stretch. A reason that returns during the stretch starts the stretch over. A one-hot cause register keeps the reason for the most recent reset, so software can read it once the system is running again.

The external pin is synchronised and filtered, so short glitches cannot restart the chip. The low-supply warning has two enables. It can act as a reset, or, with reset disabled and the interrupt enabled, it can set a sticky flag and raise an interrupt. The power-on input is also the block's synchronous, active-high reset.

Top module: `rstgen_top`

## Requirements
- R1: While `pwr_on_i` is high, `sys_rst_n_o` is 0, `cause_o` is 7'b0000010 (only bit 1, power-on), and `lv_flag_o` is 0. After release the output stays low for exactly STRETCH_CYC (1024) more samples.
- R2: `ext_rst_n_i` causes a reset only when sampled low on at least EXT_MIN_CYC (8) consecutive clock edges. A run of 7 or fewer low samples, even when repeated with a one-cycle high gap, has no effect.
- R3: A watchdog, unlock or clock-loss input sampled high drives `sys_rst_n_o` low from the next cycle. The output stays low through the last sampled high cycle and for STRETCH_CYC cycles after it.
- R4: `cause_o` is always one-hot. Bit 0 is external, bit 1 power-on, bit 2 watchdog, bit 3 PLL unlock, bit 4 PLL clock loss, bit 5 software and bit 6 low voltage.
- R5: When several sources start a reset on the same edge, the lowest-numbered cause bit is recorded.
- R6: A source that reasserts during the stretch restarts the full stretch. The cause is not changed by any source while the output is low.
- R7: A one-cycle `sw_req_i` pulse gives exactly one reset, starting one cycle later, and the request clears itself. A request made while the output is low is ignored.
- R8: With `lv_rst_en_i` high, `lvd_i` acts as a reset source with cause bit 6.
- R9: With `lv_rst_en_i` low and `lv_irq_en_i` high, `lvd_i` causes no reset. Instead it sets `lv_flag_o`, which stays set until `lv_flag_clr_i`. `lv_irq_o` is the flag gated by `lv_irq_en_i`, registered.
- R10: With both low-voltage enables low, `lvd_i` is ignored: there is no reset and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| pwr_on_i | input | 1 | Power-on detect, also the synchronous active-high reset of the block |
| ext_rst_n_i | input | 1 | Asynchronous external reset pin, active low |
| wdog_i | input | 1 | Watchdog timeout |
| pll_unlock_i | input | 1 | PLL loss of lock |
| pll_noclk_i | input | 1 | PLL loss of clock |
| sw_req_i | input | 1 | Write strobe of the software reset control bit |
| lvd_i | input | 1 | Low-voltage detect |
| lv_rst_en_i | input | 1 | Low voltage causes reset |
| lv_irq_en_i | input | 1 | Low voltage raises an interrupt |
| lv_flag_clr_i | input | 1 | Clears the sticky low-voltage flag |
| sys_rst_n_o | output | 1 | Stretched system reset, active low |
| cause_o | output | 7 | One-hot cause of the last reset |
| lv_flag_o | output | 1 | Sticky low-voltage event flag |
| lv_irq_o | output | 1 | Low-voltage interrupt |

## Verification
The hardest case to reach is a second source arriving in the middle of a running stretch. The controller must then restart its 1024-cycle count while keeping the first recorded cause. The stimulus fires a watchdog pulse and waits 300 cycles with the output confirmed low. It then pulses PLL unlock and counts the remaining low samples: a full stretch is expected, not the 724 that would remain without a restart. The pin filter is reached with runs of exactly 7 and 8 low samples and with a 7-low, 1-high, 7-low pattern. Coincident starts are swept over all fifteen combinations of four sources.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int NSRC   = 7;
  localparam int C_EXT  = 0;
  localparam int C_POR  = 1;
  localparam int C_WDOG = 2;
  localparam int C_LOCK = 3;
  localparam int C_CLK  = 4;
  localparam int C_SW   = 5;
  localparam int C_LVD  = 6;

  typedef logic [NSRC-1:0] cause_t;

  // keep only the lowest set bit: this is the coincidence priority
  function automatic cause_t lowest_one(input cause_t v);
    return v & (~v + cause_t'(1));
  endfunction
endpackage

// File: rtl/rstgen_ext_filter.sv
module rstgen_ext_filter #(
  parameter int MIN_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic qual
);
  localparam int CW = (MIN_CYC > 2) ? $clog2(MIN_CYC) : 1;
  localparam logic [CW-1:0] CMAX = CW'(MIN_CYC - 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= 1'b1;
      s2  <= 1'b1;
      cnt <= '0;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
      if (s2)
        cnt <= '0;
      else if (cnt != CMAX)
        cnt <= cnt + 1'b1;
    end
  end

  assign qual = !s2 && (cnt == CMAX);
endmodule

// File: rtl/rstgen_stretch.sv
module rstgen_stretch #(
  parameter int STRETCH = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic busy
);
  localparam int CW = (STRETCH > 2) ? $clog2(STRETCH) : 1;
  localparam logic [CW-1:0] LAST = CW'(STRETCH - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (trig) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST)
        busy <= 1'b0;
      else
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rstgen_cause.sv
module rstgen_cause
  import rstgen_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  cause_t srcs,
  input  logic   busy,
  output cause_t cause
);
  always_ff @(posedge clk) begin
    if (rst)
      cause <= cause_t'(1) << C_POR;
    else if ((|srcs) && !busy)
      cause <= lowest_one(srcs);
  end
endmodule

// File: rtl/rstgen_lvd.sv
module rstgen_lvd (
  input  logic clk,
  input  logic rst,
  input  logic lvd,
  input  logic rst_en,
  input  logic irq_en,
  input  logic clr,
  output logic lvd_rst,
  output logic flag,
  output logic irq
);
  logic set, flag_nxt;

  assign lvd_rst = lvd && rst_en;
  assign set     = lvd && !rst_en && irq_en;

  always_comb begin
    flag_nxt = flag;
    if (clr) flag_nxt = 1'b0;
    if (set) flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_nxt;
      irq  <= flag_nxt && irq_en;
    end
  end
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
  import rstgen_pkg::*;
#(
  parameter int STRETCH_CYC = 1024,
  parameter int EXT_MIN_CYC = 8
) (
  input  logic            clk,
  input  logic            pwr_on_i,
  input  logic            ext_rst_n_i,
  input  logic            wdog_i,
  input  logic            pll_unlock_i,
  input  logic            pll_noclk_i,
  input  logic            sw_req_i,
  input  logic            lvd_i,
  input  logic            lv_rst_en_i,
  input  logic            lv_irq_en_i,
  input  logic            lv_flag_clr_i,
  output logic            sys_rst_n_o,
  output logic [NSRC-1:0] cause_o,
  output logic            lv_flag_o,
  output logic            lv_irq_o
);
  logic   ext_q, lvd_rst, busy, sw_pend;
  cause_t srcs;

  rstgen_ext_filter #(.MIN_CYC(EXT_MIN_CYC)) u_ext (
    .clk(clk), .rst(pwr_on_i), .pin_n(ext_rst_n_i), .qual(ext_q));

  rstgen_lvd u_lvd (
    .clk(clk), .rst(pwr_on_i), .lvd(lvd_i), .rst_en(lv_rst_en_i),
    .irq_en(lv_irq_en_i), .clr(lv_flag_clr_i), .lvd_rst(lvd_rst),
    .flag(lv_flag_o), .irq(lv_irq_o));

  // software request bit: set by a write, gone once reset is under way
  always_ff @(posedge clk) begin
    if (pwr_on_i)
      sw_pend <= 1'b0;
    else
      sw_pend <= sw_req_i && !busy && !sw_pend;
  end

  always_comb begin
    srcs         = '0;
    srcs[C_EXT]  = ext_q;
    srcs[C_WDOG] = wdog_i;
    srcs[C_LOCK] = pll_unlock_i;
    srcs[C_CLK]  = pll_noclk_i;
    srcs[C_SW]   = sw_pend;
    srcs[C_LVD]  = lvd_rst;
  end

  rstgen_stretch #(.STRETCH(STRETCH_CYC)) u_str (
    .clk(clk), .rst(pwr_on_i), .trig(|srcs), .busy(busy));

  rstgen_cause u_cause (
    .clk(clk), .rst(pwr_on_i), .srcs(srcs), .busy(busy), .cause(cause_o));

  assign sys_rst_n_o = !busy;
endmodule

// File: rtl/rstgen_chk.sv
module rstgen_chk (
  input logic       clk,
  input logic       pwr_on_i,
  input logic       ext_rst_n_i,
  input logic       wdog_i,
  input logic       pll_unlock_i,
  input logic       pll_noclk_i,
  input logic       sw_req_i,
  input logic       lvd_i,
  input logic       lv_rst_en_i,
  input logic       lv_irq_en_i,
  input logic       lv_flag_clr_i,
  input logic       sys_rst_n_o,
  input logic [6:0] cause_o,
  input logic       lv_flag_o,
  input logic       lv_irq_o
);
  p_wdog_rst_r3: assert property (@(posedge clk) disable iff (pwr_on_i)
    (wdog_i || pll_unlock_i || pll_noclk_i) |=> !sys_rst_n_o);

  p_release_quiet_r3: assert property (@(posedge clk) disable iff (pwr_on_i)
    $rose(sys_rst_n_o) |-> $past(!wdog_i && !pll_unlock_i && !pll_noclk_i));

  p_cause_onehot_r4: assert property (@(posedge clk) disable iff (pwr_on_i)
    $countones(cause_o) == 1);

  p_cause_held_r6: assert property (@(posedge clk) disable iff (pwr_on_i)
    (!sys_rst_n_o && $past(!sys_rst_n_o)) |-> $stable(cause_o));

  p_lv_flag_set_r9: assert property (@(posedge clk) disable iff (pwr_on_i)
    (lvd_i && !lv_rst_en_i && lv_irq_en_i) |=> lv_flag_o);

  p_lv_irq_r9: assert property (@(posedge clk) disable iff (pwr_on_i)
    (lv_flag_o && lv_irq_en_i && !lv_flag_clr_i) |=> lv_irq_o);

  p_lv_quiet_r10: assert property (@(posedge clk) disable iff (pwr_on_i)
    (!lv_flag_o && !lv_irq_en_i) |=> !lv_flag_o);
endmodule

bind rstgen_top rstgen_chk u_chk (.*);

// File: tb/test_rstgen_top.sv
module test_rstgen_top;
  logic       clk = 1'b0;
  logic       pwr_on, ext_n, clr, rst_en, irq_en;
  logic [6:0] src;
  logic       rst_n, flag, irq;
  logic [6:0] cause;
  int         checks = 0;
  int         fails  = 0;

  always #5 clk = ~clk;

  rstgen_top i_rstgen_top (
    .clk(clk), .pwr_on_i(pwr_on), .ext_rst_n_i(ext_n),
    .wdog_i(src[2]), .pll_unlock_i(src[3]), .pll_noclk_i(src[4]),
    .sw_req_i(src[5]), .lvd_i(src[6]), .lv_rst_en_i(rst_en),
    .lv_irq_en_i(irq_en), .lv_flag_clr_i(clr), .sys_rst_n_o(rst_n),
    .cause_o(cause), .lv_flag_o(flag), .lv_irq_o(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [6:0] m);
    @(negedge clk); src = m;
    @(negedge clk); src = '0;
  endtask

  // counts low samples of the reset output, starting at the current sample
  task automatic count_low(output int n);
    int t = 0;
    n = 0;
    while (rst_n && t < 4) begin @(negedge clk); t++; end
    while (!rst_n && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic ext_hold(input int nlow, output int seen);
    seen = 0;
    @(negedge clk); ext_n = 1'b0;
    repeat (nlow) @(negedge clk);
    ext_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!rst_n) seen = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, seen;
    logic [6:0] m, e;
    pwr_on = 1'b1; ext_n = 1'b1; src = '0; clr = 1'b0;
    rst_en = 1'b1; irq_en = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 reset low", rst_n, 0);
    chk("R1 cause por", cause, 7'b0000010);
    chk("R1 flag clear", flag, 0);
    pwr_on = 1'b0;
    count_low(n);
    chk("R1 stretch", n, 1024);

    // single sources: watchdog, unlock, clock loss, low voltage (R3, R4, R8)
    foreach (m[k]) begin
      if (k == 2 || k == 3 || k == 4 || k == 6) begin
        pulse(7'(1) << k);
        count_low(n);
        chk(k == 6 ? "R8 stretch" : "R3 stretch", n, 1024);
        chk(k == 6 ? "R8 cause" : "R4 cause", cause, 1 << k);
      end
    end

    // software request (R7)
    pulse(7'b0100000);
    count_low(n);
    chk("R7 single reset", n, 1024);
    chk("R7 cause", cause, 7'b0100000);
    pulse(7'b0000100);
    repeat (10) @(negedge clk);
    pulse(7'b0100000);
    count_low(n);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!rst_n) seen = 1;
    end
    chk("R7 request in reset ignored", seen, 0);
    chk("R7 cause kept", cause, 7'b0000100);

    // coincident starts over four sources (R5)
    for (int c = 1; c < 16; c++) begin
      m = '0;
      m[2] = c[0]; m[3] = c[1]; m[4] = c[2]; m[6] = c[3];
      e = m & (~m + 7'd1);
      pulse(m);
      count_low(n);
      chk("R5 stretch", n, 1024);
      chk("R5 priority", cause, e);
    end

    // restart in mid stretch (R6)
    pulse(7'b0000100);
    seen = 0;
    repeat (299) begin
      @(negedge clk);
      if (rst_n) seen = 1;
    end
    chk("R6 held low", seen, 0);
    pulse(7'b0001000);
    count_low(n);
    chk("R6 restart", n, 1024);
    chk("R6 cause kept", cause, 7'b0000100);

    // external pin filter (R2)
    ext_hold(7, seen);
    chk("R2 seven low", seen, 0);
    @(negedge clk); ext_n = 1'b0;
    repeat (7) @(negedge clk);
    ext_n = 1'b1; @(negedge clk); ext_n = 1'b0;
    repeat (7) @(negedge clk);
    ext_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!rst_n) seen = 1;
    end
    chk("R2 split pulse", seen, 0);
    chk("R2 cause unchanged", cause, 7'b0000100);
    ext_hold(8, seen);
    chk("R2 eight low", seen, 1);
    count_low(n);
    chk("R2 cause ext", cause, 7'b0000001);

    // low voltage as interrupt (R9)
    rst_en = 1'b0; irq_en = 1'b1;
    pulse(7'b1000000);
    chk("R9 no reset", rst_n, 1);
    chk("R9 flag", flag, 1);
    chk("R9 irq", irq, 1);
    repeat (5) @(negedge clk);
    chk("R9 sticky", flag, 1);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R9 irq gated", irq, 0);
    chk("R9 flag kept", flag, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R9 cleared", flag, 0);

    // both enables off (R10)
    pulse(7'b1000000);
    repeat (3) @(negedge clk);
    chk("R10 no reset", rst_n, 1);
    chk("R10 no flag", flag, 0);
    chk("R10 cause unchanged", cause, 7'b0000001);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule